// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block judges each received Ethernet frame by its 48-bit destination address alone and produces one accept/reject verdict per frame. Address bytes arrive one per clock on a byte stream whose first byte is flagged as the start of a frame. While the bytes arrive, a reflected CRC-32 engine turns the address into a 6-bit multicast bin index. At the same time, the collected address is compared against a parameterised table of exact-match station addresses.

Software sets the block up through a single-cycle register write port. It writes three mode bits, the two 32-bit words of a 64-bin hash table, and the low and high words of each exact-match entry. A verdict and a one-cycle done strobe appear in the cycle after the sixth address byte has been taken. Configuration is captured at the start of each frame. A write made while a frame is in flight therefore affects only the frames that follow it.

Top module: `rx_addr_filter`

## Requirements
- R1: The bin index is formed from a reflected CRC-32 (polynomial 0xEDB88320, preset all ones) over the six address bytes in arrival order, each byte least significant bit first. The final CRC is inverted, then bit-reversed over 32 bits, and the top 6 bits of that result are the index.
- R2: Index bit 5 selects the hash word: 0 selects word 0 at register index 1 (table bits 0–31), and 1 selects word 1 at register index 2 (table bits 32–63). Index bits 4:0 select the bit within that word.
- R3: A group address (bit 0 of the first byte set) that is not broadcast is accepted in hash mode (mode bit 2) only when its selected table bit is 1. With hash mode and pass-all-group both off, such a frame is rejected.
- R4: With the promiscuous bit (mode bit 0, register index 0) set, every frame is accepted.
- R5: With the pass-all-group bit (mode bit 1) set, every group-address frame is accepted whatever the hash table holds.
- R6: The all-ones broadcast address is accepted in every mode.
- R7: Exact-match entry k has its low word at register index 4+2k, holding bytes 0–3 with byte 0 in bits 7:0. Its high word is at index 5+2k, with byte 4 in bits 7:0, byte 5 in bits 15:8 and the enable in bit 31. A unicast frame is accepted when it equals any enabled entry, and disabled entries never match.
- R8: A unicast frame that matches no enabled entry is rejected unless promiscuous mode is set. The group modes have no effect on unicast frames.
- R9: The done strobe and the verdict rise in the cycle right after the sixth address byte is taken, whatever idle gaps lie between the bytes. The verdict is low whenever done is low.
- R10: A configuration write made while a frame is being received does not affect that frame's verdict. It applies from the next frame start.
- R11: After reset, done and the verdict are low, all modes are off and all entries are disabled.
- R12: A start-of-frame byte that arrives mid-address abandons the partial address and begins a new one, so only one verdict is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| byte_valid | input | 1 | Address byte present this cycle |
| byte_sof | input | 1 | Marks the first address byte of a frame |
| byte_data | input | 8 | Address byte |
| frame_done | output | 1 | One-cycle strobe, verdict is valid |
| frame_pass | output | 1 | 1 accepts the frame, 0 rejects it |

## Verification
The checker watches, on every cycle, the properties that need no address arithmetic. These are: promiscuous and broadcast frames always pass, a verdict never appears without done, done is a single-cycle pulse that follows a taken byte, and the captured mode stays fixed while a frame is in flight. The bench scenarios alone cover the bin index and word selection, which need an independently computed CRC. They also cover exact-match entries with enables, mid-frame writes, abandoned partial addresses and byte streams with gaps.

// File: rtl/afilt_pkg.sv
// Shared types and the CRC step for the receive address filter.
// Assumes the reflected CRC-32 polynomial and LSB-first bit order.
package afilt_pkg;

    localparam int          MAC_W    = 48;
    localparam int          IDX_W    = 6;
    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

    // Mode bits captured per frame
    typedef struct packed {
        logic hash_en;
        logic all_grp;
        logic promisc;
    } mode_t;

    // One exact-match entry
    typedef struct packed {
        logic             en;
        logic [MAC_W-1:0] mac;
    } entry_t;

    // Advance a reflected CRC by one byte, LSB first
    function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                             input logic [7:0]  d);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/afilt_cfg.sv
// Configuration store: staged registers written by software, and an
// active copy taken at each frame start. Assumes at most one write per
// cycle; unmapped indices are ignored.
module afilt_cfg
    import afilt_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int CFG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              snap,
    output mode_t             act_mode,
    output logic [63:0]       act_hash,
    output entry_t            act_ent [N_ENT]
);

    mode_t       stg_mode;
    logic [63:0] stg_hash;
    entry_t      stg_ent [N_ENT];

    // Staged mode and hash words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_mode <= '0;
            stg_hash <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(0)) stg_mode <= mode_t'(cfg_wdata[2:0]);
            if (cfg_addr == CFG_AW'(1)) stg_hash[31:0]  <= cfg_wdata;
            if (cfg_addr == CFG_AW'(2)) stg_hash[63:32] <= cfg_wdata;
        end
    end

    // Staged exact-match entries, one register pair each
    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        localparam logic [CFG_AW-1:0] LO_IDX = CFG_AW'(4 + 2*k);
        localparam logic [CFG_AW-1:0] HI_IDX = CFG_AW'(5 + 2*k);

        // Write one half of entry k
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_ent[k] <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == LO_IDX) stg_ent[k].mac[31:0] <= cfg_wdata;
                if (cfg_addr == HI_IDX) begin
                    stg_ent[k].mac[47:32] <= cfg_wdata[15:0];
                    stg_ent[k].en         <= cfg_wdata[31];
                end
            end
        end

        // Capture entry k at frame start
        always_ff @(posedge clk) begin
            if (!rst_n)    act_ent[k] <= '0;
            else if (snap) act_ent[k] <= stg_ent[k];
        end
    end

    // Capture mode and hash at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode <= '0;
            act_hash <= '0;
        end else if (snap) begin
            act_mode <= stg_mode;
            act_hash <= stg_hash;
        end
    end

endmodule

// File: rtl/afilt_crc.sv
// Serial CRC engine: one address byte per clock, preset on the start
// byte. Presents the next CRC and the bin index derived from it so the
// verdict can be registered on the same edge as the last byte.
module afilt_crc
    import afilt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  logic [7:0]       d,
    output logic [IDX_W-1:0] idx_nxt
);

    logic [31:0] crc_q;
    logic [31:0] crc_nxt;

    // Next CRC value, preset when a frame restarts
    always_comb begin
        crc_nxt = crc_q;
        if (step) crc_nxt = crc_step(restart ? 32'hFFFF_FFFF : crc_q, d);
    end

    // Hold the running CRC
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= 32'hFFFF_FFFF;
        else        crc_q <= crc_nxt;
    end

    // Index = top bits of bit-reversed inverted CRC
    for (genvar j = 0; j < IDX_W; j++) begin : g_idx
        assign idx_nxt[j] = ~crc_nxt[IDX_W-1-j];
    end

endmodule

// File: rtl/afilt_match.sv
// Exact-match comparator bank: flags a hit when the address equals any
// enabled entry. Purely combinational.
module afilt_match
    import afilt_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic [MAC_W-1:0] addr,
    input  entry_t           ent [N_ENT],
    output logic             hit
);

    logic [N_ENT-1:0] eq;

    for (genvar k = 0; k < N_ENT; k++) begin : g_cmp
        assign eq[k] = ent[k].en && (ent[k].mac == addr);
    end

    assign hit = |eq;

endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination address filter top. Collects six address bytes,
// runs the bin hash and exact-match compare, and registers one verdict
// per frame. Assumes bytes arrive in wire order, first byte flagged by
// byte_sof; bytes outside a frame are ignored.
module rx_addr_filter
    import afilt_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int CFG_AW = $clog2(2*N_ENT + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              byte_valid,
    input  logic              byte_sof,
    input  logic [7:0]        byte_data,
    output logic              frame_done,
    output logic              frame_pass
);

    localparam int NBYTES = MAC_W / 8;
    localparam int CNT_W  = $clog2(NBYTES + 1);

    logic              start_b;
    logic              cont_b;
    logic              last_b;
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [MAC_W-1:0]  addr_q;
    logic [MAC_W-1:0]  addr_nxt;
    logic [IDX_W-1:0]  idx_nxt;
    logic              hit;
    logic              verdict;
    mode_t             act_mode;
    logic [2:0]        act_mode_bits;
    logic [63:0]       act_hash;
    entry_t            act_ent [N_ENT];

    assign start_b       = byte_valid && byte_sof;
    assign cont_b        = byte_valid && !byte_sof && busy_q;
    assign last_b        = cont_b && (cnt_q == CNT_W'(NBYTES - 1));
    assign act_mode_bits = act_mode;

    afilt_cfg #(.N_ENT(N_ENT), .CFG_AW(CFG_AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .snap      (start_b),
        .act_mode  (act_mode),
        .act_hash  (act_hash),
        .act_ent   (act_ent)
    );

    afilt_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (start_b || cont_b),
        .restart (start_b),
        .d       (byte_data),
        .idx_nxt (idx_nxt)
    );

    afilt_match #(.N_ENT(N_ENT)) u_match (
        .addr (addr_nxt),
        .ent  (act_ent),
        .hit  (hit)
    );

    // Next address: first byte clears, later bytes fill in order
    always_comb begin
        addr_nxt = addr_q;
        if (start_b) begin
            addr_nxt      = '0;
            addr_nxt[7:0] = byte_data;
        end else if (cont_b) begin
            addr_nxt[{cnt_q, 3'b000} +: 8] = byte_data;
        end
    end

    // Verdict in priority order over the completed address
    always_comb begin
        if (act_mode.promisc || (&addr_nxt))  verdict = 1'b1;
        else if (addr_nxt[0]) begin
            if (act_mode.all_grp)             verdict = 1'b1;
            else if (act_mode.hash_en)        verdict = act_hash[idx_nxt];
            else                              verdict = 1'b0;
        end else                              verdict = hit;
    end

    // Byte counter and frame-in-progress flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_b) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
        end else if (cont_b) begin
            busy_q <= !last_b;
            cnt_q  <= last_b ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // Address collection register
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_nxt;
    end

    // Done strobe and verdict, registered with the last byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            frame_pass <= 1'b0;
        end else begin
            frame_done <= last_b;
            frame_pass <= last_b && verdict;
        end
    end

endmodule

// File: rtl/afilt_chk.sv
// Cycle-level checker for rx_addr_filter, bound into every instance.
module afilt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        byte_valid,
    input logic        byte_sof,
    input logic        frame_done,
    input logic        frame_pass,
    input logic [47:0] addr_q,
    input logic [2:0]  act_mode,
    input logic        busy_q
);

    // R4: promiscuous frames always pass
    assert_promisc_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && act_mode[0]) |-> frame_pass);

    // R6: broadcast always passes
    assert_bcast_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && (&addr_q)) |-> frame_pass);

    // R9: verdict only with done
    assert_pass_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pass |-> frame_done);

    // R9: done is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R9: done follows a taken byte
    assert_done_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> $past(byte_valid));

    // R10: captured mode holds while a frame is in flight
    assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !(byte_valid && byte_sof)) |=> $stable(act_mode));

endmodule

bind rx_addr_filter afilt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_sof   (byte_sof),
    .frame_done (frame_done),
    .frame_pass (frame_pass),
    .addr_q     (addr_q),
    .act_mode   (act_mode_bits),
    .busy_q     (busy_q)
);

// File: tb/tb_rx_addr_filter.sv
// Scoreboard bench: driver tasks queue expected verdicts, a monitor
// pops them on every done strobe.
module tb_rx_addr_filter;

    localparam int N_ENT  = 4;
    localparam int CFG_AW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              byte_valid = 1'b0;
    logic              byte_sof = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              frame_done;
    logic              frame_pass;

    int total = 0;
    int bad   = 0;
    bit exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    rx_addr_filter #(.N_ENT(N_ENT), .CFG_AW(CFG_AW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .byte_valid(byte_valid), .byte_sof(byte_sof),
        .byte_data(byte_data), .frame_done(frame_done), .frame_pass(frame_pass)
    );

    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    // Reference bin index from R1
    function automatic logic [5:0] ref_idx(input logic [47:0] m);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] r;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[0] ^ m[i];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        c = ~c;
        for (int i = 0; i < 32; i++) r[31-i] = c[i];
        return r[31:26];
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] v);
        cfg_we = 1'b1; cfg_addr = CFG_AW'(idx); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_entry(input int k, input logic [47:0] m, input logic en);
        wr(4 + 2*k, m[31:0]);
        wr(5 + 2*k, {en, 15'b0, m[47:32]});
    endtask

    task automatic put_byte(input logic [7:0] d, input logic s);
        byte_valid = 1'b1; byte_data = d; byte_sof = s;
        @(negedge clk);
        byte_valid = 1'b0; byte_sof = 1'b0;
    endtask

    // Send bytes first..5 of address m, check done timing (R9)
    task automatic send_from(input logic [47:0] m, input int first, input int gap,
                             input bit exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        for (int i = first; i < 6; i++) begin
            put_byte(m[8*i +: 8], i == 0);
            if (i < 5) begin
                check("R9 no early done", frame_done, 1'b0);
                repeat (gap) @(negedge clk);
            end
        end
        check("R9 done after sixth byte", frame_done, 1'b1);
        @(negedge clk);
        check("R9 done single cycle", frame_done, 1'b0);
    endtask

    task automatic send(input logic [47:0] m, input bit exp, input string tag);
        send_from(m, 0, 0, exp, tag);
    endtask

    // Monitor: compare each verdict with the queue head
    always @(negedge clk) begin
        if (rst_n && frame_done) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R9 unexpected done actual=1 expected=0");
            end else begin
                check(tag_q.pop_front(), frame_pass, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [47:0] stn   = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        logic [47:0] other = mk(8'h02, 8'h99, 8'h88, 8'h77, 8'h66, 8'h01);
        logic [47:0] e1    = mk(8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F);
        logic [47:0] e2    = mk(8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC);
        logic [47:0] grp   = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
        logic [47:0] bc    = '1;
        logic [5:0]  ix;

        repeat (3) @(negedge clk);
        check("R11 reset done", frame_done, 1'b0);
        check("R11 reset pass", frame_pass, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        send(stn, 1'b0, "R11 entries disabled after reset");
        send(bc, 1'b1, "R6 broadcast with no modes");

        set_entry(0, stn, 1'b1);
        send(stn, 1'b1, "R7 station entry match");
        send(other, 1'b0, "R8 unmatched unicast");
        set_entry(1, e1, 1'b0);
        set_entry(2, e2, 1'b1);
        send(e2, 1'b1, "R7 entry 2 match");
        send(e1, 1'b0, "R7 disabled entry ignored");
        send_from(e2, 0, 3, 1'b1, "R9 gapped bytes");

        send(grp, 1'b0, "R3 group rejected with hash off");
        ix = ref_idx(grp);
        wr(0, 32'h4);
        wr(ix[5] ? 1 : 2, 32'hFFFF_FFFF);
        wr(ix[5] ? 2 : 1, ~(32'h1 << ix[4:0]));
        send(grp, 1'b0, "R2 other word and other bits set");
        wr(ix[5] ? 2 : 1, 32'h1 << ix[4:0]);
        send(grp, 1'b1, "R1 hash bin selected");
        send(other, 1'b0, "R8 hash mode ignores unicast");

        wr(0, 32'h2);
        wr(1, 32'h0);
        wr(2, 32'h0);
        send(grp, 1'b1, "R5 pass-all-group with empty table");
        send(other, 1'b0, "R8 pass-all-group ignores unicast");
        send(bc, 1'b1, "R6 broadcast in group mode");

        wr(0, 32'h0);
        put_byte(other[7:0], 1'b1);
        put_byte(other[15:8], 1'b0);
        wr(0, 32'h1);
        send_from(other, 2, 0, 1'b0, "R10 mid-frame write not applied");
        send(other, 1'b1, "R4 promiscuous from next frame");

        wr(0, 32'h0);
        put_byte(8'hEE, 1'b1);
        put_byte(8'hDD, 1'b0);
        put_byte(8'hCC, 1'b0);
        send(stn, 1'b1, "R12 restart on new start byte");

        repeat (4) @(negedge clk);
        check("R9 all verdicts seen", exp_q.size() == 0, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule